// File: doc/BRIEF.md
# ISA Peripheral Chip-Select Decoder

This block watches ISA I/O cycles and produces two active-low chip selects for an IDE optical-drive port. The primary select covers an 8-aligned base window of either four or eight locations. The alternate select covers a window starting at a programmable base, with a programmable length of one to eight bytes. The alternate select stays off while its base is zero.

For every cycle the block also produces a per-bit enable for the ISA data-bus drivers. Reads that hit either window enable the whole byte. There are two exceptions. A global disable bit suppresses the whole byte. A separate bit suppresses only data bit 7 at alternate base plus one, because a floppy controller shares that address and drives that bit.

The drive's interrupt request passes through a polarity stage before it leaves the block. The polarity bit resets to active high. Software can rewrite it with an I/O write to control base plus one. All outputs are registered and follow the bus inputs by one clock.

Top module: `periph_cs_decode`

## Requirements
- R1: With the wide bit clear, the primary select decodes addresses whose bits [15:3] equal those of the primary base and whose bit 2 is 0 (four locations).
- R2: With the wide bit set, the primary select decodes all eight locations whose bits [15:3] match the primary base.
- R3: Bits [2:0] of the primary base are ignored, so the window is always 8-aligned.
- R4: The alternate select decodes addresses from alt base to alt base plus L, where L is the 3-bit length field (0 gives 1 byte, 7 gives 8 bytes).
- R5: An alternate base of zero keeps the alternate select deasserted for every address.
- R6: A select goes low (active) one clock after a cycle in which AEN is low, the address is in its window, and the read or write strobe (both active low) is active. It returns high one clock after these conditions stop holding.
- R7: Data enables are all ones one clock after a read that hits either window. They are zero after writes, after misses and while idle.
- R8: With the bit-7 block bit set, a read of alt base plus one gives enables 0x7F. Other alternate addresses still give 0xFF.
- R9: With the bus-disable bit set, the data enables stay zero for reads of both windows, while the selects still assert.
- R10: irq_o is a registered copy of the drive request XOR'd with the inverted polarity bit. Polarity resets to 1. An I/O write with AEN low to control base plus one loads polarity from write-data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | ISA I/O address |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| aen_i | input | 1 | Address enable, high during DMA cycles |
| wdata_i | input | 8 | ISA write data |
| pri_base_i | input | 16 | Primary window base |
| alt_base_i | input | 16 | Alternate window base, zero disables |
| ctl_base_i | input | 16 | Control block base |
| wide_en_i | input | 1 | Primary window widened to 8 locations |
| alt_len_i | input | 3 | Alternate window length minus one |
| b7_block_i | input | 1 | Suppress bit 7 at alternate base plus one |
| bus_dis_i | input | 1 | Suppress all read-data driving |
| drv_irq_i | input | 1 | Interrupt request from the drive |
| pri_cs_no | output | 1 | Primary chip select, active low |
| alt_cs_no | output | 1 | Alternate chip select, active low |
| sd_oe_o | output | 8 | Per-bit ISA data drive enable |
| irq_o | output | 1 | Interrupt after polarity |

## Verification
The assertions check four things on every cycle:
- The selects release one clock after an idle bus or a DMA cycle.
- Data enables are zero unless a read was active, and zero under bus-disable.
- A zero alternate base never produces an alternate select.
- Bit 7 is never enabled while bit 6 is off.

Only the bench scenarios can show the exact window edges for each length and width setting, the ignored primary-base low bits, and the 0x7F pattern at alternate base plus one. They also show the polarity register changing after a control write.

// File: rtl/periph_cs_pkg.sv
package periph_cs_pkg;
  typedef struct packed {
    logic pri;
    logic alt;
    logic alt_p1;
  } hit_t;
endpackage

// File: rtl/pri_win.sv
module pri_win #(
  parameter int ADDR_W  = 16,
  parameter int ALIGN_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wide_i,
  output logic              hit_o
);
  // base low bits ignored: window is 2**ALIGN_W aligned
  assign hit_o = (addr_i[ADDR_W-1:ALIGN_W] == base_i[ADDR_W-1:ALIGN_W]) &&
                 (wide_i || !addr_i[ALIGN_W-1]);
endmodule

// File: rtl/alt_win.sv
module alt_win #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              hit_o,
  output logic              p1_o
);
  logic [ADDR_W-1:0] off;
  logic              en;

  assign en    = |base_i;
  assign off   = addr_i - base_i;
  assign hit_o = en && (addr_i >= base_i) && (off <= ADDR_W'(len_i));
  assign p1_o  = hit_o && (off == ADDR_W'(1));
endmodule

// File: rtl/irq_pol.sv
module irq_pol #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ctl_base_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_i,
  output logic              irq_o
);
  logic pol_q;
  logic ctl_wr;

  assign ctl_wr = wr_i && (addr_i == ctl_base_i + ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b1;
      irq_o <= 1'b0;
    end else begin
      if (ctl_wr) pol_q <= wdata_i[0];
      irq_o <= irq_i ^ ~pol_q;
    end
  end
endmodule

// File: rtl/periph_cs_decode.sv
module periph_cs_decode
  import periph_cs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 3,
  parameter int ALIGN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic              aen_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] pri_base_i,
  input  logic [ADDR_W-1:0] alt_base_i,
  input  logic [ADDR_W-1:0] ctl_base_i,
  input  logic              wide_en_i,
  input  logic [LEN_W-1:0]  alt_len_i,
  input  logic              b7_block_i,
  input  logic              bus_dis_i,
  input  logic              drv_irq_i,
  output logic              pri_cs_no,
  output logic              alt_cs_no,
  output logic [DATA_W-1:0] sd_oe_o,
  output logic              irq_o
);
  localparam int MSB = DATA_W - 1;

  hit_t              hit;
  logic              rd, wr, cyc;
  logic [DATA_W-1:0] oe_d;

  assign rd  = !aen_i && !ior_ni;
  assign wr  = !aen_i && !iow_ni;
  assign cyc = rd || wr;

  pri_win #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_pri (
    .addr_i (addr_i),
    .base_i (pri_base_i),
    .wide_i (wide_en_i),
    .hit_o  (hit.pri)
  );

  alt_win #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_alt (
    .addr_i (addr_i),
    .base_i (alt_base_i),
    .len_i  (alt_len_i),
    .hit_o  (hit.alt),
    .p1_o   (hit.alt_p1)
  );

  irq_pol #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .ctl_base_i (ctl_base_i),
    .wr_i       (wr),
    .wdata_i    (wdata_i),
    .irq_i      (drv_irq_i),
    .irq_o      (irq_o)
  );

  always_comb begin
    oe_d = '0;
    if (rd && (hit.pri || hit.alt) && !bus_dis_i) begin
      oe_d = '1;
      if (b7_block_i && hit.alt_p1) oe_d[MSB] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_cs_no <= 1'b1;
      alt_cs_no <= 1'b1;
      sd_oe_o   <= '0;
    end else begin
      pri_cs_no <= !(cyc && hit.pri);
      alt_cs_no <= !(cyc && hit.alt);
      sd_oe_o   <= oe_d;
    end
  end
endmodule

// File: rtl/periph_cs_chk.sv
module periph_cs_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ior_ni,
  input logic              iow_ni,
  input logic              aen_i,
  input logic [ADDR_W-1:0] alt_base_i,
  input logic              bus_dis_i,
  input logic              pri_cs_no,
  input logic              alt_cs_no,
  input logic [DATA_W-1:0] sd_oe_o
);
  // R6
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ior_ni && iow_ni) |=> (pri_cs_no && alt_cs_no));
  // R6
  aen_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |=> (pri_cs_no && alt_cs_no && sd_oe_o == '0));
  // R7
  oe_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ior_ni |=> (sd_oe_o == '0));
  // R9
  bus_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dis_i |=> (sd_oe_o == '0));
  // R5
  alt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_base_i == '0) |=> alt_cs_no);
  // R8
  b7_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_oe_o[DATA_W-2] |-> !sd_oe_o[DATA_W-1]);
endmodule

bind periph_cs_decode periph_cs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ior_ni     (ior_ni),
  .iow_ni     (iow_ni),
  .aen_i      (aen_i),
  .alt_base_i (alt_base_i),
  .bus_dis_i  (bus_dis_i),
  .pri_cs_no  (pri_cs_no),
  .alt_cs_no  (alt_cs_no),
  .sd_oe_o    (sd_oe_o)
);

// File: tb/periph_cs_decode_bench.sv
module periph_cs_decode_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0, pri_base = 16'h0170, alt_base = 16'h0376, ctl_base = 16'h0120;
  logic        ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0;
  logic [7:0]  wdata = '0;
  logic        wide = 1'b0, b7blk = 1'b0, busdis = 1'b0, dirq = 1'b0;
  logic [2:0]  alen = '0;
  logic        pcs_n, acs_n, irq;
  logic [7:0]  oe;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_cs_decode u_periph_cs_decode (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ior_ni(ior_n), .iow_ni(iow_n),
    .aen_i(aen), .wdata_i(wdata), .pri_base_i(pri_base), .alt_base_i(alt_base),
    .ctl_base_i(ctl_base), .wide_en_i(wide), .alt_len_i(alen), .b7_block_i(b7blk),
    .bus_dis_i(busdis), .drv_irq_i(dirq), .pri_cs_no(pcs_n), .alt_cs_no(acs_n),
    .sd_oe_o(oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; outputs sampled at the following negedge
  task automatic access(input logic [15:0] a, input logic rd, input logic wr);
    @(negedge clk);
    addr = a; ior_n = !rd; iow_n = !wr;
    @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    ior_n = 1'b1; iow_n = 1'b1; aen = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [9:0] pk(logic p, logic a, logic [7:0] o);
    return {p, a, o};
  endfunction

  task automatic t_reset();
    chk("R6 reset", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    chk("R10 reset", {9'd0, irq}, 10'd0);
  endtask

  task automatic t_pri_narrow();
    wide = 0;
    access(16'h0173, 1, 0); chk("R1 last in", pk(pcs_n, acs_n, oe), pk(0, 1, 8'hFF));
    access(16'h0174, 1, 0); chk("R1 bit2 out", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    access(16'h0168, 1, 0); chk("R7 miss", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    idle();
  endtask

  task automatic t_pri_wide();
    wide = 1;
    access(16'h0177, 1, 0); chk("R2 top in", pk(pcs_n, acs_n, oe), pk(0, 1, 8'hFF));
    access(16'h0178, 1, 0); chk("R2 above out", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    idle(); wide = 0;
  endtask

  task automatic t_align();
    pri_base = 16'h0175;
    access(16'h0170, 1, 0); chk("R3 aligned", pk(pcs_n, acs_n, oe), pk(0, 1, 8'hFF));
    idle(); pri_base = 16'h0170;
  endtask

  task automatic t_alt_len();
    alen = 3'd0;
    access(16'h0376, 1, 0); chk("R4 len1 in", pk(pcs_n, acs_n, oe), pk(1, 0, 8'hFF));
    access(16'h0377, 1, 0); chk("R4 len1 out", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    alen = 3'd3;
    access(16'h0379, 1, 0); chk("R4 len4 last", pk(pcs_n, acs_n, oe), pk(1, 0, 8'hFF));
    access(16'h037A, 1, 0); chk("R4 len4 past", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    access(16'h0375, 1, 0); chk("R4 below", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    alen = 3'd7;
    access(16'h037D, 1, 0); chk("R4 len8 last", pk(pcs_n, acs_n, oe), pk(1, 0, 8'hFF));
    idle(); alen = 3'd0;
  endtask

  task automatic t_alt_off();
    alt_base = 16'h0000;
    access(16'h0000, 1, 0); chk("R5 zero base", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    idle(); alt_base = 16'h0376;
  endtask

  task automatic t_strobe();
    @(negedge clk); aen = 1;
    access(16'h0170, 1, 0); chk("R6 aen high", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
    @(negedge clk); aen = 0;
    access(16'h0170, 0, 1); chk("R7 write no drive", pk(pcs_n, acs_n, oe), pk(0, 1, 8'h00));
    idle(); chk("R6 release", pk(pcs_n, acs_n, oe), pk(1, 1, 8'h00));
  endtask

  task automatic t_b7();
    b7blk = 1; alen = 3'd1;
    access(16'h0377, 1, 0); chk("R8 plus1", pk(pcs_n, acs_n, oe), pk(1, 0, 8'h7F));
    access(16'h0376, 1, 0); chk("R8 base", pk(pcs_n, acs_n, oe), pk(1, 0, 8'hFF));
    idle(); b7blk = 0; alen = 3'd0;
  endtask

  task automatic t_busdis();
    busdis = 1;
    access(16'h0170, 1, 0); chk("R9 pri", pk(pcs_n, acs_n, oe), pk(0, 1, 8'h00));
    access(16'h0376, 1, 0); chk("R9 alt", pk(pcs_n, acs_n, oe), pk(1, 0, 8'h00));
    idle(); busdis = 0;
  endtask

  task automatic t_irq();
    @(negedge clk); dirq = 1;
    @(negedge clk); chk("R10 high pol", {9'd0, irq}, 10'd1);
    @(negedge clk); wdata = 8'h00;
    access(16'h0121, 0, 1);
    idle();
    chk("R10 low pol hi", {9'd0, irq}, 10'd0);
    @(negedge clk); dirq = 0;
    @(negedge clk); chk("R10 low pol lo", {9'd0, irq}, 10'd1);
    wdata = 8'h01;
    access(16'h0121, 0, 1);
    idle();
    chk("R10 restore", {9'd0, irq}, 10'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pri_narrow();
    t_pri_wide();
    t_align();
    t_alt_len();
    t_alt_off();
    t_strobe();
    t_b7();
    t_busdis();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule